// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt request flags from the peripherals of a small microcontroller. It picks one request to present to the CPU as a 16-bit vector-table address. The CPU reads the handler address from that table location. The table is 32 words long and sits at the top of the address space. Each of its 32 slots has a priority number, and the slot address is the table base plus twice that priority. Slot 31 is the reset slot and outranks every other slot. Slot 30 is a non-maskable slot, which three sources share. Slots 29 down to 18 hold ordinary maskable requests. Several flags may be ORed into a single slot. The slots below 18 have no sources and can never be chosen.

Each source has a flag and an enable bit. The three classes gate requests in different ways:
- Reset-class flags are always pending.
- Non-maskable flags need only their own enable bit.
- Maskable flags need their own enable bit and also the global interrupt enable.

When the block is idle it latches the highest pending slot. It then raises `irq_valid` and holds the address steady until the CPU acknowledges. An acknowledge does two things in the same cycle. It pulses a request to drop the global enable. If the slot has exactly one maskable source, it also pulses a clear to that source's flag. Slots that have several sources keep their flags, and software clears them.

Top module: `intvec_ctrl`

## Requirements
- R1: After reset `irq_valid`, `vec_addr`, `src_clr` and `gie_clr` are all zero.
- R2: While `irq_valid` is high, `vec_addr` equals 0xFFC0 + 2 × slot. This address is always even and lies between 0xFFE4 and 0xFFFE.
- R3: When several requests are pending in the same cycle, the slot with the highest number wins.
- R4: Sources 0–2 (slot 31) are pending whenever their flag is set, whatever their enable bits and `gie`.
- R5: Sources 3–5 (slot 30) are pending when both the flag and the source's own enable are set. `gie` has no effect on them.
- R6: Sources 6–33 are pending only when the flag, the source's own enable and `gie` are all set.
- R7: Once `irq_valid` is high, `irq_valid` and `vec_addr` stay unchanged until `irq_ack`, even if a higher request arrives in the meantime.
- R8: Raising `irq_ack` while `irq_valid` is high pulses `gie_clr` in that same cycle, and `irq_valid` falls at the next clock edge.
- R9: An acknowledge of a slot with one maskable source (sources 6, 9, 10 and 17) pulses only that source's bit of `src_clr`, in the same cycle as `gie_clr`.
- R10: An acknowledge of any other slot leaves `src_clr` at zero, and that slot's flags stay set.
- R11: Raising `irq_ack` while `irq_valid` is low has no effect on any output.
- R12: When the block is idle, a newly pending request raises `irq_valid` at the next clock edge.
- R13: Sources map to slots as follows:
  - 0–2 → 31
  - 3–5 → 30
  - 6 → 29
  - 7–8 → 28
  - 9 → 26
  - 10 → 25
  - 11–12 → 24
  - 13–14 → 23
  - 15–16 → 22
  - 17 → 21
  - 18–25 → 19
  - 26–33 → 18

  Slots 27, 20 and 17–0 have no sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_flag | input | 34 | Request flags, one bit per source |
| src_en | input | 34 | Per-source enable bits |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_valid | output | 1 | A vector address is being presented |
| vec_addr | output | 16 | Vector-table address of the selected slot |
| src_clr | output | 34 | One-cycle clear pulse for a single-source flag |
| gie_clr | output | 1 | One-cycle request to clear the global enable |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a table base of 0xFFC0 and the fixed map of 34 sources. This small configuration makes exhaustive sweeps practical:
- Every source is raised on its own.
- Every source is tried under each of the two blocked gating conditions.
- Every unordered pair of sources is raised together, 561 pairs in all, which reaches every priority contest and every same-slot collision.

Directed sequences cover the hold-while-presenting behaviour, the flags that remain after a multi-source acknowledge, and an acknowledge that arrives while the block is idle.

// File: rtl/intvec_pkg.sv
// Package: slot layout, source map and class encoding for the interrupt vector controller.
// Assumes sources are numbered from the highest-priority slot downward, contiguously.
package intvec_pkg;

    localparam int SLOTS    = 32;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int MASK_TOP = 29;
    localparam int MASK_BOT = 18;
    localparam int RST_SLOT = SLOTS - 1;
    localparam int NMI_SLOT = SLOTS - 2;

    typedef enum logic [1:0] {
        CLS_RESET = 2'd0,
        CLS_NMI   = 2'd1,
        CLS_MASK  = 2'd2,
        CLS_NONE  = 2'd3
    } slot_cls_e;

    // Number of sources feeding a slot.
    function automatic int slot_srcs(input int s);
        case (s)
            31, 30:          return 3;
            29, 26, 25, 21:  return 1;
            28, 24, 23, 22:  return 2;
            19, 18:          return 8;
            default:         return 0;
        endcase
    endfunction

    // Index of the first source of slot s (all higher slots come first).
    function automatic int first_src(input int s);
        int acc;
        acc = 0;
        for (int k = SLOTS - 1; k > s; k--) acc += slot_srcs(k);
        return acc;
    endfunction

    localparam int NSRC    = first_src(-1);
    localparam int RST_CNT = slot_srcs(RST_SLOT);

    // Slot that source i feeds.
    function automatic int src_slot(input int i);
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (i >= first_src(s) && i < first_src(s) + slot_srcs(s)) return s;
        end
        return 0;
    endfunction

    // Gating class of a slot.
    function automatic slot_cls_e slot_class(input int s);
        if (s == RST_SLOT) return CLS_RESET;
        if (s == NMI_SLOT) return CLS_NMI;
        if (s >= MASK_BOT && s <= MASK_TOP && slot_srcs(s) > 0) return CLS_MASK;
        return CLS_NONE;
    endfunction

endpackage

// File: rtl/intvec_gate.sv
// Module: qualifies each source by its class rules and ORs sources into per-slot pending bits.
// Assumes the package source map; slots without sources are tied to zero.
module intvec_gate
    import intvec_pkg::*;
(
    input  logic [NSRC-1:0]  src_flag,
    input  logic [NSRC-1:0]  src_en,
    input  logic             gie,
    output logic [SLOTS-1:0] slot_pend
);

    logic [NSRC-1:0] qual;

    // Per-source qualification chosen by the class of the slot it feeds.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam slot_cls_e CLS = slot_class(src_slot(i));
        if (CLS == CLS_RESET) begin : g_rst
            assign qual[i] = src_flag[i];
        end else if (CLS == CLS_NMI) begin : g_nmi
            assign qual[i] = src_flag[i] & src_en[i];
        end else begin : g_msk
            assign qual[i] = src_flag[i] & src_en[i] & gie;
        end
    end

    // Per-slot OR of its contiguous source range.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int F = first_src(s);
        localparam int C = slot_srcs(s);
        if (C > 0) begin : g_used
            assign slot_pend[s] = |qual[F+C-1:F];
        end else begin : g_empty
            assign slot_pend[s] = 1'b0;
        end
    end

endmodule

// File: rtl/intvec_prio.sv
// Module: fixed-priority encoder, highest set index wins.
// Assumes N is at least 2.
module intvec_prio #(
    parameter int N     = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan upward so the last (highest) set bit is kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k]) begin
                found = 1'b1;
                idx   = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/intvec_hold.sv
// Module: latches the winning slot while idle and presents it until acknowledged.
// Assumes synchronous active-low reset; ack is ignored while nothing is presented.
module intvec_hold
    import intvec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              found,
    input  logic [SLOT_W-1:0] win_slot,
    input  logic              irq_ack,
    output logic              irq_valid,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              ack_fire
);

    typedef enum logic {ST_IDLE, ST_SHOW} hold_st_e;
    hold_st_e st_q;

    assign irq_valid = (st_q == ST_SHOW);
    assign ack_fire  = irq_valid & irq_ack;

    // State and latched slot update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cur_slot <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (found) begin
                    st_q     <= ST_SHOW;
                    cur_slot <= win_slot;
                end
                ST_SHOW: if (irq_ack) begin
                    st_q     <= ST_IDLE;
                    cur_slot <= '0;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/intvec_clr.sv
// Module: decodes acknowledge pulses into per-source clears for single-source maskable slots.
// Assumes ack_fire is high for exactly the acknowledge cycle.
module intvec_clr
    import intvec_pkg::*;
(
    input  logic              ack_fire,
    input  logic [SLOT_W-1:0] cur_slot,
    output logic [NSRC-1:0]   src_clr
);

    // One clear line per source; only single-source maskable slots get one.
    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        localparam int S = src_slot(i);
        if (slot_class(S) == CLS_MASK && slot_srcs(S) == 1) begin : g_auto
            assign src_clr[i] = ack_fire && (cur_slot == SLOT_W'(S));
        end else begin : g_keep
            assign src_clr[i] = 1'b0;
        end
    end

endmodule

// File: rtl/intvec_ctrl.sv
// Module: top of the interrupt vector controller; gates, prioritizes, holds and decodes.
// Assumes peripherals clear a flag on its src_clr pulse and the CPU drops gie on gie_clr.
module intvec_ctrl
    import intvec_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_flag,
    input  logic [NSRC-1:0]   src_en,
    input  logic              gie,
    input  logic              irq_ack,
    output logic              irq_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [NSRC-1:0]   src_clr,
    output logic              gie_clr
);

    localparam int PAD_W = ADDR_W - SLOT_W - 1;

    logic [SLOTS-1:0]  slot_pend;
    logic              found;
    logic [SLOT_W-1:0] win_slot;
    logic [SLOT_W-1:0] cur_slot;
    logic              ack_fire;

    intvec_gate u_gate (
        .src_flag  (src_flag),
        .src_en    (src_en),
        .gie       (gie),
        .slot_pend (slot_pend)
    );

    intvec_prio #(.N(SLOTS)) u_prio (
        .req   (slot_pend),
        .found (found),
        .idx   (win_slot)
    );

    intvec_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .found     (found),
        .win_slot  (win_slot),
        .irq_ack   (irq_ack),
        .irq_valid (irq_valid),
        .cur_slot  (cur_slot),
        .ack_fire  (ack_fire)
    );

    intvec_clr u_clr (
        .ack_fire (ack_fire),
        .cur_slot (cur_slot),
        .src_clr  (src_clr)
    );

    // Table address from the latched slot; zero while idle.
    always_comb begin
        vec_addr = irq_valid ? (VEC_BASE + {{PAD_W{1'b0}}, cur_slot, 1'b0}) : '0;
    end

    assign gie_clr = ack_fire;

endmodule

// File: rtl/intvec_ctrl_chk.sv
// Checker: temporal properties of the interrupt vector controller ports, bound to the top.
module intvec_ctrl_chk
    import intvec_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_flag,
    input logic              irq_ack,
    input logic              irq_valid,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [NSRC-1:0]   src_clr,
    input logic              gie_clr
);

    localparam logic [ADDR_W-1:0] LO_ADDR  = VEC_BASE + ADDR_W'(2 * MASK_BOT);
    localparam logic [ADDR_W-1:0] HI_ADDR  = VEC_BASE + ADDR_W'(2 * RST_SLOT);

    assert_vec_in_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (vec_addr[0] == 1'b0 && vec_addr >= LO_ADDR && vec_addr <= HI_ADDR));

    assert_reset_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_valid && (|src_flag[RST_CNT-1:0])) |=> (irq_valid && vec_addr == HI_ADDR));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> (irq_valid && $stable(vec_addr)));

    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> !irq_valid);

    assert_gie_clr_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |-> gie_clr);

    assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_clr));

    assert_clr_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr != '0) |-> (gie_clr && irq_ack));

    assert_idle_ack_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (!gie_clr && src_clr == '0));

endmodule

bind intvec_ctrl intvec_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_flag  (src_flag),
    .irq_ack   (irq_ack),
    .irq_valid (irq_valid),
    .vec_addr  (vec_addr),
    .src_clr   (src_clr),
    .gie_clr   (gie_clr)
);

// File: tb/intvec_ctrl_tb_top.sv
// Bench: sweeps single sources, gating cases and all source pairs; directed hold/ack cases.
module intvec_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 34;
    localparam int BASE = 'hFFC0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] src_flag;
    logic [NS-1:0] src_en;
    logic          gie;
    logic          irq_ack;
    logic          irq_valid;
    logic [15:0]   vec_addr;
    logic [NS-1:0] src_clr;
    logic          gie_clr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    intvec_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_flag  (src_flag),
        .src_en    (src_en),
        .gie       (gie),
        .irq_ack   (irq_ack),
        .irq_valid (irq_valid),
        .vec_addr  (vec_addr),
        .src_clr   (src_clr),
        .gie_clr   (gie_clr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R12 watchdog actual=%0d expected<=100000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Bench model of the source map (R13).
    function automatic int b_slot(input int i);
        if (i < 3)  return 31;
        if (i < 6)  return 30;
        if (i == 6) return 29;
        if (i < 9)  return 28;
        if (i == 9) return 26;
        if (i == 10) return 25;
        if (i < 13) return 24;
        if (i < 15) return 23;
        if (i < 17) return 22;
        if (i == 17) return 21;
        if (i < 26) return 19;
        return 18;
    endfunction

    function automatic bit b_single(input int i);
        return (i == 6 || i == 9 || i == 10 || i == 17);
    endfunction

    // Expected winning slot, -1 for none (R3..R6).
    function automatic int b_winner(input logic [NS-1:0] f, input logic [NS-1:0] e, input logic g);
        int best;
        best = -1;
        for (int i = 0; i < NS; i++) begin
            bit q;
            if (i < 3)      q = f[i];
            else if (i < 6) q = f[i] & e[i];
            else            q = f[i] & e[i] & g;
            if (q && b_slot(i) > best) best = b_slot(i);
        end
        return best;
    endfunction

    // Expected clear vector when acknowledging slot w (R9, R10).
    function automatic logic [NS-1:0] b_clr(input logic [NS-1:0] f, input int w);
        logic [NS-1:0] r;
        r = '0;
        for (int i = 0; i < NS; i++)
            if (f[i] && b_slot(i) == w && b_single(i)) r[i] = 1'b1;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One clock edge, then check the presented vector (R12, R2).
    task automatic latch_check(input int w, input string req);
        @(posedge clk);
        @(negedge clk);
        if (w < 0) chk(!irq_valid, req, irq_valid, 0);
        else chk(irq_valid && vec_addr == 16'(BASE + 2*w), req,
                 {irq_valid, vec_addr}, {1'b1, 16'(BASE + 2*w)});
    endtask

    // Acknowledge, check pulses, then clear the bench-side flags.
    task automatic ack_clean(input logic [NS-1:0] exp_clr);
        irq_ack = 1'b1;
        #1;
        chk(gie_clr == 1'b1, "R8 gie_clr", gie_clr, 1);
        chk(src_clr == exp_clr, "R9/R10 src_clr", src_clr, exp_clr);
        @(posedge clk);
        @(negedge clk);
        irq_ack  = 1'b0;
        chk(!irq_valid, "R8 valid drop", irq_valid, 0);
        src_flag = '0;
        gie      = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; src_flag = '0; src_en = '0; gie = 1'b0; irq_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(irq_valid == 0 && vec_addr == 0 && src_clr == 0 && gie_clr == 0, "R1 reset",
            {irq_valid, vec_addr, src_clr, gie_clr}, 0);

        // Each source alone, all enables on (R13, R2, R9, R10, R12).
        src_en = '1;
        for (int i = 0; i < NS; i++) begin
            gie = 1'b1;
            src_flag = '0; src_flag[i] = 1'b1;
            latch_check(b_slot(i), "R13 single source");
            ack_clean(b_clr(src_flag, b_slot(i)));
        end

        // Gating: own enable off (R4, R6), then gie off (R4, R5, R6).
        for (int i = 0; i < NS; i++) begin
            for (int mode = 0; mode < 2; mode++) begin
                int w;
                src_en = '1; gie = 1'b1;
                if (mode == 0) src_en[i] = 1'b0; else gie = 1'b0;
                src_flag = '0; src_flag[i] = 1'b1;
                w = b_winner(src_flag, src_en, gie);
                latch_check(w, mode == 0 ? "R4/R6 own enable off" : "R5/R6 gie off");
                if (irq_valid) ack_clean(b_clr(src_flag, w));
                else begin
                    src_flag = '0;
                    @(negedge clk);
                end
            end
        end

        // All pairs raised together (R3).
        src_en = '1;
        for (int i = 0; i < NS; i++) begin
            for (int j = i + 1; j < NS; j++) begin
                int w;
                gie = 1'b1;
                src_flag = '0; src_flag[i] = 1'b1; src_flag[j] = 1'b1;
                w = b_winner(src_flag, src_en, gie);
                latch_check(w, "R3 pair winner");
                ack_clean(b_clr(src_flag, w));
            end
        end

        // Hold while a higher request arrives (R7).
        gie = 1'b1; src_flag = '0; src_flag[26] = 1'b1;
        latch_check(18, "R7 low latched");
        src_flag[0] = 1'b1;
        for (int k = 0; k < 3; k++) latch_check(18, "R7 held");
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0; gie = 1'b0;
        latch_check(31, "R7 next winner after ack");
        ack_clean('0);

        // Multi-source slot keeps its flag (R10).
        src_flag = '0; src_flag[18] = 1'b1; gie = 1'b1;
        latch_check(19, "R10 port slot");
        irq_ack = 1'b1;
        #1;
        chk(src_clr == '0, "R10 no clear", src_clr, 0);
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0; gie = 1'b1;
        latch_check(19, "R10 flag still pending");
        ack_clean('0);

        // Acknowledge while idle (R11).
        src_flag = '0;
        irq_ack = 1'b1;
        #1;
        chk(gie_clr == 0 && src_clr == 0, "R11 idle ack pulses", {gie_clr, src_clr}, 0);
        @(posedge clk);
        @(negedge clk);
        chk(!irq_valid && vec_addr == 0, "R11 idle ack state", {irq_valid, vec_addr}, 0);
        irq_ack = 1'b0;
        latch_check(-1, "R11 still idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule